// File: doc/BRIEF.md
# Fabric Reset Gating Controller

This block sits between the processor subsystem's reset logic and the programmable fabric. It decides whether a processor soft reset should also erase the fabric configuration. By default every reset clears the fabric. After the fabric has been configured, software can write a two-bit command that blocks the clear request. Later processor resets then leave the fabric running.

The block holds a single gate bit, and only the power-on reset initialises it. The soft reset that the bit gates never touches it. Three one-time fuse bits are OR-ed together. When any of them is set, the stored gate is overridden and every processor reset clears the fabric.

The clear toward the fabric is an active-low strobe of fixed length. Status outputs report:
- the stored gate;
- the effective gate after the fuse override;
- a sticky flag for an illegal command;
- the captured fuse bits.

Top module: `fgc_top`

## Requirements
- R1: While `por_rst` is high, `fab_clear_n` is low, and it stays low until the PULSE_CYCLES-th (default 4th) rising edge that samples `por_rst` low, after which it is high.
- R2: After power-on reset, `stat_gate_stored`, `stat_gate_eff` and `stat_cmd_err` are all 0, so the fabric is cleared by a processor reset.
- R3: A write with command code {cmd_enable,cmd_gate} = 2'b00 leaves `stat_gate_stored` unchanged and clears `stat_cmd_err`.
- R4: A write with code 2'b01 sets `stat_gate_stored` to 1 and clears `stat_cmd_err`. With no fuse set, a later `soft_rst_req` leaves `fab_clear_n` high.
- R5: A write with code 2'b10 sets `stat_gate_stored` to 0 and clears `stat_cmd_err`. A later `soft_rst_req` drives `fab_clear_n` low for exactly PULSE_CYCLES cycles, starting in the cycle after the edge that samples the request.
- R6: A write with the invalid code 2'b11 leaves `stat_gate_stored` unchanged and sets `stat_cmd_err`. The flag stays set until the next write with a valid code.
- R7: If any bit of `fuse_in` is set, `stat_gate_eff` is 0 and every `soft_rst_req` produces the clear pulse of R5, whatever the stored gate is. `stat_gate_stored` still shows the stored value.
- R8: `stat_fuses` shows `fuse_in` captured one clock earlier, bit for bit. The fuse override takes effect from that same cycle.
- R9: `soft_rst_req` never changes `stat_gate_stored` or `stat_cmd_err`.
- R10: A passed `soft_rst_req` arriving while a clear pulse is in progress restarts the full PULSE_CYCLES count.
- R11: `stat_gate_eff` is 1 only when `stat_gate_stored` is 1 and `stat_fuses` is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Synchronous active-high power-on reset |
| soft_rst_req | input | 1 | Processor soft-reset request, one cycle per event |
| cmd_wr | input | 1 | Command write strobe |
| cmd_enable | input | 1 | Command enable bit (upper bit of code) |
| cmd_gate | input | 1 | Command gate bit (lower bit of code) |
| fuse_in | input | NUM_FUSES | Override fuse bits |
| fab_clear_n | output | 1 | Active-low clear strobe toward the fabric |
| stat_gate_stored | output | 1 | Stored gate bit (1 = soft reset blocked) |
| stat_gate_eff | output | 1 | Gate after fuse override |
| stat_cmd_err | output | 1 | Sticky invalid-command flag |
| stat_fuses | output | NUM_FUSES | Captured fuse bits |

## Verification
The bound checker watches a set of rules on every cycle:
- each command code moves the stored gate and the error flag as specified;
- the gate stays put in any cycle without a write, soft resets included;
- a passed soft reset always pulls the clear low on the next cycle;
- a blocked gate keeps the clear high;
- the effective gate is consistent with the stored bit and the fuses.

Some properties can only be shown by the bench's sweep, which covers every start state, command code and fuse pattern. These are the exact pulse length, the release timing after power-on, the retrigger behaviour and the persistence of the error flag across a soft reset.

// File: rtl/fgc_pkg.sv
package fgc_pkg;

    // Command code is {enable, gate}
    typedef enum logic [1:0] {
        CMD_HOLD  = 2'b00,
        CMD_BLOCK = 2'b01,
        CMD_PASS  = 2'b10,
        CMD_BAD   = 2'b11
    } gate_cmd_e;

    // Decoded action of one command write
    typedef struct packed {
        logic load;       // update stored gate
        logic next_gate;  // value to load
        logic set_err;    // raise sticky error
        logic clr_err;    // drop sticky error
    } cmd_act_t;

    // Status view of the gate
    typedef struct packed {
        logic stored;
        logic eff;
        logic err;
    } gate_stat_t;

    function automatic cmd_act_t decode_cmd(input logic wr, input gate_cmd_e code);
        cmd_act_t a;
        a = '0;
        if (wr) begin
            unique case (code)
                CMD_HOLD: begin
                    a.clr_err = 1'b1;
                end
                CMD_BLOCK: begin
                    a.load      = 1'b1;
                    a.next_gate = 1'b1;
                    a.clr_err   = 1'b1;
                end
                CMD_PASS: begin
                    a.load      = 1'b1;
                    a.next_gate = 1'b0;
                    a.clr_err   = 1'b1;
                end
                CMD_BAD: begin
                    a.set_err = 1'b1;
                end
                default: a = '0;
            endcase
        end
        return a;
    endfunction

endpackage

// File: rtl/fgc_cmd_decode.sv
module fgc_cmd_decode
    import fgc_pkg::*;
(
    input  logic     cmd_wr,
    input  logic     cmd_enable,
    input  logic     cmd_gate,
    output cmd_act_t act
);

    gate_cmd_e code;

    always_comb begin
        code = gate_cmd_e'({cmd_enable, cmd_gate});
        act  = decode_cmd(cmd_wr, code);
    end

endmodule

// File: rtl/fgc_gate_reg.sv
module fgc_gate_reg
    import fgc_pkg::*;
(
    input  logic     clk,
    input  logic     por_rst,
    input  cmd_act_t act,
    output logic     gate_q,
    output logic     err_q
);

    // Only power-on reset initialises this state; soft reset is not an input here.
    always_ff @(posedge clk) begin
        if (por_rst) begin
            gate_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (act.load) begin
                gate_q <= act.next_gate;
            end
            if (act.set_err) begin
                err_q <= 1'b1;
            end else if (act.clr_err) begin
                err_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/fgc_fuse_override.sv
module fgc_fuse_override #(
    parameter int NUM_FUSES = 3
) (
    input  logic                 clk,
    input  logic                 por_rst,
    input  logic [NUM_FUSES-1:0] fuse_in,
    input  logic                 gate_q,
    output logic [NUM_FUSES-1:0] fuse_q,
    output logic                 eff_block
);

    logic any_fuse;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_FUSES; gi++) begin : g_fuse
            always_ff @(posedge clk) begin
                if (por_rst) begin
                    fuse_q[gi] <= 1'b0;
                end else begin
                    fuse_q[gi] <= fuse_in[gi];
                end
            end
        end
    endgenerate

    always_comb begin
        any_fuse  = |fuse_q;
        eff_block = gate_q & ~any_fuse;
    end

endmodule

// File: rtl/fgc_pulse_gen.sv
module fgc_pulse_gen #(
    parameter int PULSE_CYCLES = 4
) (
    input  logic clk,
    input  logic por_rst,
    input  logic fire,
    output logic clear_n
);

    localparam int CW = $clog2(PULSE_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(PULSE_CYCLES);

    logic [CW-1:0] cnt_q;

    // Reset preloads the counter so power-on also yields a full clear.
    always_ff @(posedge clk) begin
        if (por_rst) begin
            cnt_q <= LOAD_VAL;
        end else if (fire) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    always_comb begin
        clear_n = (cnt_q == '0);
    end

endmodule

// File: rtl/fgc_top.sv
module fgc_top
    import fgc_pkg::*;
#(
    parameter int NUM_FUSES    = 3,
    parameter int PULSE_CYCLES = 4
) (
    input  logic                 clk,
    input  logic                 por_rst,
    input  logic                 soft_rst_req,
    input  logic                 cmd_wr,
    input  logic                 cmd_enable,
    input  logic                 cmd_gate,
    input  logic [NUM_FUSES-1:0] fuse_in,
    output logic                 fab_clear_n,
    output logic                 stat_gate_stored,
    output logic                 stat_gate_eff,
    output logic                 stat_cmd_err,
    output logic [NUM_FUSES-1:0] stat_fuses
);

    cmd_act_t   act;
    gate_stat_t st;
    logic       gate_q;
    logic       err_q;
    logic       eff_block;
    logic       fire;

    fgc_cmd_decode u_dec (
        .cmd_wr     (cmd_wr),
        .cmd_enable (cmd_enable),
        .cmd_gate   (cmd_gate),
        .act        (act)
    );

    fgc_gate_reg u_gate (
        .clk     (clk),
        .por_rst (por_rst),
        .act     (act),
        .gate_q  (gate_q),
        .err_q   (err_q)
    );

    fgc_fuse_override #(.NUM_FUSES(NUM_FUSES)) u_fuse (
        .clk       (clk),
        .por_rst   (por_rst),
        .fuse_in   (fuse_in),
        .gate_q    (gate_q),
        .fuse_q    (stat_fuses),
        .eff_block (eff_block)
    );

    // Gate decision uses the state held before any same-cycle write.
    always_comb begin
        fire      = soft_rst_req & ~eff_block;
        st.stored = gate_q;
        st.eff    = eff_block;
        st.err    = err_q;
    end

    fgc_pulse_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
        .clk     (clk),
        .por_rst (por_rst),
        .fire    (fire),
        .clear_n (fab_clear_n)
    );

    assign stat_gate_stored = st.stored;
    assign stat_gate_eff    = st.eff;
    assign stat_cmd_err     = st.err;

endmodule

// File: rtl/fgc_chk.sv
module fgc_chk #(
    parameter int NUM_FUSES = 3
) (
    input logic                 clk,
    input logic                 por_rst,
    input logic                 soft_rst_req,
    input logic                 cmd_wr,
    input logic                 cmd_enable,
    input logic                 cmd_gate,
    input logic                 fab_clear_n,
    input logic                 stat_gate_stored,
    input logic                 stat_gate_eff,
    input logic                 stat_cmd_err,
    input logic [NUM_FUSES-1:0] stat_fuses
);

    // R4
    cmd_block_chk: assert property (@(posedge clk) disable iff (por_rst)
        (cmd_wr && !cmd_enable && cmd_gate) |=> (stat_gate_stored && !stat_cmd_err));

    // R5
    cmd_pass_chk: assert property (@(posedge clk) disable iff (por_rst)
        (cmd_wr && cmd_enable && !cmd_gate) |=> (!stat_gate_stored && !stat_cmd_err));

    // R6
    cmd_bad_chk: assert property (@(posedge clk) disable iff (por_rst)
        (cmd_wr && cmd_enable && cmd_gate) |=> ($stable(stat_gate_stored) && stat_cmd_err));

    // R3
    cmd_hold_chk: assert property (@(posedge clk) disable iff (por_rst)
        (cmd_wr && !cmd_enable && !cmd_gate) |=> ($stable(stat_gate_stored) && !stat_cmd_err));

    // R9
    no_write_stable_chk: assert property (@(posedge clk) disable iff (por_rst)
        !cmd_wr |=> ($stable(stat_gate_stored) && $stable(stat_cmd_err)));

    // R7
    passed_reset_clears_chk: assert property (@(posedge clk) disable iff (por_rst)
        (soft_rst_req && !stat_gate_eff) |=> !fab_clear_n);

    // R4
    blocked_stays_high_chk: assert property (@(posedge clk) disable iff (por_rst)
        (stat_gate_eff && fab_clear_n && !soft_rst_req) |=> fab_clear_n);

    // R11
    eff_consistent_chk: assert property (@(posedge clk) disable iff (por_rst)
        stat_gate_eff |-> (stat_gate_stored && (stat_fuses == '0)));

endmodule

bind fgc_top fgc_chk #(.NUM_FUSES(NUM_FUSES)) u_chk (
    .clk              (clk),
    .por_rst          (por_rst),
    .soft_rst_req     (soft_rst_req),
    .cmd_wr           (cmd_wr),
    .cmd_enable       (cmd_enable),
    .cmd_gate         (cmd_gate),
    .fab_clear_n      (fab_clear_n),
    .stat_gate_stored (stat_gate_stored),
    .stat_gate_eff    (stat_gate_eff),
    .stat_cmd_err     (stat_cmd_err),
    .stat_fuses       (stat_fuses)
);

// File: tb/sim_fgc_top.sv
`timescale 1ns/1ps
module sim_fgc_top;

    localparam int NF = 3;
    localparam int PL = 4;

    logic          clk = 1'b0;
    logic          por_rst;
    logic          soft_rst_req;
    logic          cmd_wr;
    logic          cmd_enable;
    logic          cmd_gate;
    logic [NF-1:0] fuse_in;
    logic          fab_clear_n;
    logic          stat_gate_stored;
    logic          stat_gate_eff;
    logic          stat_cmd_err;
    logic [NF-1:0] stat_fuses;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    logic exp_gate;
    logic exp_err;

    always #2.5 clk = ~clk;

    fgc_top #(.NUM_FUSES(NF), .PULSE_CYCLES(PL)) u0 (
        .clk              (clk),
        .por_rst          (por_rst),
        .soft_rst_req     (soft_rst_req),
        .cmd_wr           (cmd_wr),
        .cmd_enable       (cmd_enable),
        .cmd_gate         (cmd_gate),
        .fuse_in          (fuse_in),
        .fab_clear_n      (fab_clear_n),
        .stat_gate_stored (stat_gate_stored),
        .stat_gate_eff    (stat_gate_eff),
        .stat_cmd_err     (stat_cmd_err),
        .stat_fuses       (stat_fuses)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic write_cmd(input logic [1:0] code);
        cmd_wr = 1'b1;
        {cmd_enable, cmd_gate} = code;
        step();
        cmd_wr = 1'b0;
        case (code)
            2'b00: exp_err = 1'b0;
            2'b01: begin exp_gate = 1'b1; exp_err = 1'b0; end
            2'b10: begin exp_gate = 1'b0; exp_err = 1'b0; end
            default: exp_err = 1'b1;
        endcase
    endtask

    // Issue one soft reset and watch the clear for PL+2 cycles
    task automatic soft_and_watch(input string req, input bit expect_pulse);
        soft_rst_req = 1'b1;
        step();
        soft_rst_req = 1'b0;
        for (int i = 1; i <= PL + 2; i++) begin
            check(req, 8'(fab_clear_n), 8'((expect_pulse && i <= PL) ? 1'b0 : 1'b1));
            step();
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        por_rst = 1'b1; soft_rst_req = 1'b0; cmd_wr = 1'b0;
        cmd_enable = 1'b0; cmd_gate = 1'b0; fuse_in = '0;
        exp_gate = 1'b0; exp_err = 1'b0;
        step(); step(); step();
        // R1, R2: reset state
        check("R1", 8'(fab_clear_n), 8'd0);
        check("R2", 8'(stat_gate_stored), 8'd0);
        check("R2", 8'(stat_gate_eff), 8'd0);
        check("R2", 8'(stat_cmd_err), 8'd0);
        por_rst = 1'b0;
        for (int i = 1; i <= PL + 1; i++) begin
            step();
            check("R1", 8'(fab_clear_n), 8'((i < PL) ? 1'b0 : 1'b1));
        end

        // Sweep: start state x command code x fuse pattern
        for (int s = 0; s < 2; s++) begin
            for (int c = 0; c < 4; c++) begin
                for (int f = 0; f < (1 << NF); f++) begin
                    fuse_in = NF'(f);
                    step();
                    // R8
                    check("R8", 8'(stat_fuses), 8'(f));
                    write_cmd(s[0] ? 2'b01 : 2'b10);
                    write_cmd(2'(c));
                    check(c == 3 ? "R6" : (c == 0 ? "R3" : (c == 1 ? "R4" : "R5")),
                          8'(stat_gate_stored), 8'(exp_gate));
                    check(c == 3 ? "R6" : "R3", 8'(stat_cmd_err), 8'(exp_err));
                    // R11, R7
                    check("R11", 8'(stat_gate_eff), 8'(exp_gate && (f == 0)));
                    soft_and_watch(f != 0 ? "R7" : (exp_gate ? "R4" : "R5"),
                                   !(exp_gate && (f == 0)));
                    // R9: state survives soft reset, error flag too (R6)
                    check("R9", 8'(stat_gate_stored), 8'(exp_gate));
                    check("R6", 8'(stat_cmd_err), 8'(exp_err));
                end
            end
        end

        // R6: error clears on next valid command
        fuse_in = '0;
        step();
        write_cmd(2'b11);
        check("R6", 8'(stat_cmd_err), 8'd1);
        write_cmd(2'b00);
        check("R6", 8'(stat_cmd_err), 8'd0);

        // R10: retrigger restarts the count
        write_cmd(2'b10);
        soft_rst_req = 1'b1;
        step();
        soft_rst_req = 1'b0;
        step();
        soft_rst_req = 1'b1;
        step();
        soft_rst_req = 1'b0;
        for (int i = 1; i <= PL + 1; i++) begin
            check("R10", 8'(fab_clear_n), 8'((i <= PL) ? 1'b0 : 1'b1));
            step();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule